// File: doc/BRIEF.md
# NAND Bank Select and Strobe Decoder

This block sits between a simple on-chip bus and a shared 8-bit NAND flash bus that serves several external banks. A small control register carries, for every bank, an enable bit and an assert bit. A bank's active-low chip enable drops only while both of its bits are set. Software can clear every assert bit at once and leave the enables alone, so a single write deselects all chips.

Each bank owns an address window whose base is a parameter. A byte write into a window becomes one NAND bus cycle. The offset of the access inside the window selects the kind of cycle: one offset bit marks an address-latch cycle, another marks a command-latch cycle, and neither marks a data cycle. A request that sets both bits is refused and reported. Reads from a window produce a read strobe and return the byte sampled from the flash bus. The ready/busy pin from the flash is brought through a two-flop synchronizer and shown as a status output.

Every bus cycle has three parts. A setup cycle puts the latch lines and the data on the bus. A strobe lasts a parameterised number of clocks. A hold cycle keeps the lines steady after the strobe rises.

Top module: `nand_bank_strobe`

## Requirements
- R1: After reset the control register reads 0, every chip enable is high, the latch lines are low, both strobes are high, the data driver is off, and the busy and error outputs are low.
- R2: For bank n, control bit 2n is its enable and bit 2n+1 is its assert. nandCeN[n] is low exactly when both bits are 1. A control write takes effect in the cycle after the clock edge that samples it.
- R3: Writing the register value with the assert mask 0xAA cleared raises every chip enable and leaves the enable bits readable as written. Writing 0 raises every chip enable and clears the whole register.
- R4: A write whose address lies in a bank window is decoded by offset. Offset bit 16 set means an address cycle (nandAle high). Offset bit 15 set means a command cycle (nandCle high). Neither bit set means a data cycle. All other offset bits are ignored, and nandCle and nandAle are never high together.
- R5: A write with both offset bits 15 and 16 set starts no bus cycle. memErr goes high for exactly the one cycle after the request is sampled, and memBusy stays low.
- R6: A request whose address lies in no bank window is ignored: no strobe, no busy and no error.
- R7: For an accepted write, nandWeN is low for exactly WE_PULSE cycles, starting in the second cycle after the request is sampled. The latch lines and nandDout take their values in the first cycle after the request is sampled and hold them through one cycle after nandWeN rises. nandDoe is high over the same span.
- R8: A read in a window drives nandReN low for WE_PULSE cycles with both latch lines low and the data driver off. nandDin is sampled at the clock edge that ends the strobe, and rdData is shown with a one-cycle rdValid pulse in the next cycle.
- R9: memBusy is high from the cycle after an accepted request through the hold cycle. It is low again in the cycle after the hold cycle, which is when the latch lines drop.
- R10: readyStat follows nandRb through two flip-flops. A change of nandRb shows on readyStat after the second clock edge that follows it, not after the first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWe | input | 1 | Control register write strobe |
| ctrlWdata | input | 2*NB | Control register write value |
| ctrlRdata | output | 2*NB | Current control register value |
| memReq | input | 1 | Window access request (one cycle) |
| memWe | input | 1 | 1 = write, 0 = read |
| memAddr | input | 32 | Byte address of the access |
| memWdata | input | 8 | Write byte |
| memBusy | output | 1 | Bus cycle in progress |
| memErr | output | 1 | One-cycle pulse for a rejected request |
| rdData | output | 8 | Byte read from the flash bus |
| rdValid | output | 1 | One-cycle pulse when rdData is valid |
| nandCeN | output | NB | Active-low chip enables, one per bank |
| nandCle | output | 1 | Command latch enable |
| nandAle | output | 1 | Address latch enable |
| nandWeN | output | 1 | Active-low write strobe |
| nandReN | output | 1 | Active-low read strobe |
| nandDout | output | 8 | Byte driven to the flash bus |
| nandDoe | output | 1 | Output enable for nandDout |
| nandDin | input | 8 | Byte from the flash bus |
| nandRb | input | 1 | Raw ready/busy pin |
| readyStat | output | 1 | Synchronized ready status |

## Verification
Let E0 be the edge that samples a request. The latch lines, the data and busy change in the cycle after E0. The strobe is low in cycles 2 to WE_PULSE+1 after E0. The hold cycle comes next, and busy and the lines fall one cycle later. A rejected request raises memErr only in the cycle after E0. A read gives rdValid in the hold cycle. A control write shows on the chip enables one cycle after its edge, and readyStat trails the pin by two edges. The bench drives every input on the falling clock edge and then steps one falling edge at a time. It checks each output in the exact cycle named above, and it also checks the cycle before and the cycle after, so a result that comes one cycle early or one cycle late is caught.

// File: rtl/nbs_pkg.sv
package nbs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_STRB  = 2'd2,
    ST_HOLD  = 2'd3
  } nbsState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;     // latch a new bus cycle
    logic isRead;   // cycle being loaded is a read
    logic flagErr;  // rejected request
    logic strbLow;  // strobe phase active
    logic capture;  // last strobe cycle
    logic active;   // any phase of a cycle
  } nbsStrobe_t;
endpackage

// File: rtl/nbs_ctrl.sv
module nbs_ctrl
  import nbs_pkg::*;
#(
  parameter int WE_PULSE = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       memReq,
  input  logic       memWe,
  input  logic       winHit,
  input  logic       bothSel,
  output nbsStrobe_t strb,
  output logic       memBusy
);
  localparam int CW = $clog2(WE_PULSE + 1);

  nbsState_t state;
  logic [CW-1:0] cnt;
  logic idle, accept, reject;

  assign idle   = (state == ST_IDLE);
  assign reject = memReq && idle && winHit && memWe && bothSel;
  assign accept = memReq && idle && winHit && !(memWe && bothSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (accept) state <= ST_SETUP;
        ST_SETUP: begin
          state <= ST_STRB;
          cnt   <= CW'(WE_PULSE - 1);
        end
        ST_STRB: begin
          if (cnt == '0) state <= ST_HOLD;
          else cnt <= cnt - 1'b1;
        end
        default:  state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.load    = accept;
    strb.isRead  = !memWe;
    strb.flagErr = reject;
    strb.strbLow = (state == ST_STRB);
    strb.capture = (state == ST_STRB) && (cnt == '0);
    strb.active  = !idle;
  end

  assign memBusy = !idle;
endmodule

// File: rtl/nbs_datapath.sv
module nbs_datapath
  import nbs_pkg::*;
#(
  parameter int NB = 4,
  parameter int WIN_BITS = 17,
  parameter int ALE_BIT = 16,
  parameter int CLE_BIT = 15,
  parameter logic [NB-1:0][31:0] BANK_BASE = '0
) (
  input  logic            clk,
  input  logic            rstN,
  input  nbsStrobe_t      strb,
  input  logic            ctrlWe,
  input  logic [2*NB-1:0] ctrlWdata,
  output logic [2*NB-1:0] ctrlRdata,
  input  logic            memWe,
  input  logic [31:0]     memAddr,
  input  logic [7:0]      memWdata,
  output logic            winHit,
  output logic            bothSel,
  output logic            memErr,
  output logic [7:0]      rdData,
  output logic            rdValid,
  output logic [NB-1:0]   nandCeN,
  output logic            nandCle,
  output logic            nandAle,
  output logic            nandWeN,
  output logic            nandReN,
  output logic [7:0]      nandDout,
  output logic            nandDoe,
  input  logic [7:0]      nandDin,
  input  logic            nandRb,
  output logic            readyStat
);
  localparam int CTRL_W = 2 * NB;

  logic [CTRL_W-1:0] ctrlReg;
  logic [NB-1:0] bankHit;
  logic cleR, aleR, rdFlag, errR, rdValidR;
  logic [7:0] doutR, rdDataR;
  logic [1:0] rbSync;

  // window decode, one comparator per bank
  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign bankHit[b] = (memAddr[31:WIN_BITS] == BANK_BASE[b][31:WIN_BITS]);
    assign nandCeN[b] = !(ctrlReg[2*b] && ctrlReg[2*b+1]);
  end

  assign winHit  = |bankHit;
  assign bothSel = memAddr[ALE_BIT] && memAddr[CLE_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (ctrlWe) ctrlReg <= ctrlWdata;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cleR   <= 1'b0;
      aleR   <= 1'b0;
      rdFlag <= 1'b0;
      doutR  <= '0;
    end else if (strb.load) begin
      cleR   <= memWe && memAddr[CLE_BIT];
      aleR   <= memWe && memAddr[ALE_BIT];
      rdFlag <= strb.isRead;
      doutR  <= memWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errR     <= 1'b0;
      rdValidR <= 1'b0;
      rdDataR  <= '0;
    end else begin
      errR     <= strb.flagErr;
      rdValidR <= strb.capture && rdFlag;
      if (strb.capture && rdFlag) rdDataR <= nandDin;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rbSync <= '0;
    else rbSync <= {rbSync[0], nandRb};
  end

  assign ctrlRdata = ctrlReg;
  assign memErr    = errR;
  assign rdData    = rdDataR;
  assign rdValid   = rdValidR;
  assign nandCle   = strb.active && cleR;
  assign nandAle   = strb.active && aleR;
  assign nandWeN   = !(strb.strbLow && !rdFlag);
  assign nandReN   = !(strb.strbLow && rdFlag);
  assign nandDout  = doutR;
  assign nandDoe   = strb.active && !rdFlag;
  assign readyStat = rbSync[1];
endmodule

// File: rtl/nand_bank_strobe.sv
module nand_bank_strobe
  import nbs_pkg::*;
#(
  parameter int NB = 4,
  parameter int WE_PULSE = 2,
  parameter int WIN_BITS = 17,
  parameter int ALE_BIT = 16,
  parameter int CLE_BIT = 15,
  parameter logic [NB-1:0][31:0] BANK_BASE =
    {32'h0800_0000, 32'h0C00_0000, 32'h1400_0000, 32'h1800_0000}
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            ctrlWe,
  input  logic [2*NB-1:0] ctrlWdata,
  output logic [2*NB-1:0] ctrlRdata,
  input  logic            memReq,
  input  logic            memWe,
  input  logic [31:0]     memAddr,
  input  logic [7:0]      memWdata,
  output logic            memBusy,
  output logic            memErr,
  output logic [7:0]      rdData,
  output logic            rdValid,
  output logic [NB-1:0]   nandCeN,
  output logic            nandCle,
  output logic            nandAle,
  output logic            nandWeN,
  output logic            nandReN,
  output logic [7:0]      nandDout,
  output logic            nandDoe,
  input  logic [7:0]      nandDin,
  input  logic            nandRb,
  output logic            readyStat
);
  nbsStrobe_t strb;
  logic winHit, bothSel;

  nbs_ctrl #(.WE_PULSE(WE_PULSE)) u_ctrl (
    .clk(clk), .rstN(rstN), .memReq(memReq), .memWe(memWe),
    .winHit(winHit), .bothSel(bothSel), .strb(strb), .memBusy(memBusy)
  );

  nbs_datapath #(
    .NB(NB), .WIN_BITS(WIN_BITS), .ALE_BIT(ALE_BIT), .CLE_BIT(CLE_BIT),
    .BANK_BASE(BANK_BASE)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .ctrlWe(ctrlWe),
    .ctrlWdata(ctrlWdata), .ctrlRdata(ctrlRdata), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .winHit(winHit),
    .bothSel(bothSel), .memErr(memErr), .rdData(rdData), .rdValid(rdValid),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandDout(nandDout),
    .nandDoe(nandDoe), .nandDin(nandDin), .nandRb(nandRb),
    .readyStat(readyStat)
  );
endmodule

// File: rtl/nbs_checker.sv
module nbs_checker #(
  parameter int NB = 4,
  parameter int WE_PULSE = 2
) (
  input logic            clk,
  input logic            rstN,
  input logic [2*NB-1:0] ctrlRdata,
  input logic            memBusy,
  input logic            memErr,
  input logic [NB-1:0]   nandCeN,
  input logic            nandCle,
  input logic            nandAle,
  input logic            nandWeN,
  input logic            nandReN,
  input logic            nandRb,
  input logic            readyStat
);
  logic [7:0] lowCnt;
  logic [1:0] upCyc;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowCnt <= '0;
      upCyc  <= '0;
    end else begin
      lowCnt <= nandWeN ? 8'd0 : lowCnt + 8'd1;
      if (upCyc != 2'd3) upCyc <= upCyc + 2'd1;
    end
  end

  // R4: latch lines exclusive
  a_r4_latch_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(nandCle && nandAle));

  // R8: never both strobes at once
  a_r8_strobe_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(!nandWeN && !nandReN));

  // R7: lines settled before the strobe falls and held as it rises
  a_r7_setup: assert property (@(posedge clk) disable iff (!rstN)
    $fell(nandWeN) |-> $stable(nandCle) && $stable(nandAle));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> $stable(nandCle) && $stable(nandAle));
  a_r7_width: assert property (@(posedge clk) disable iff (!rstN)
    $rose(nandWeN) |-> lowCnt == 8'(WE_PULSE));

  // R5: a rejected request never overlaps a bus cycle
  a_r5_err_idle: assert property (@(posedge clk) disable iff (!rstN)
    memErr |-> !memBusy && nandWeN);

  // R9: strobes only while busy
  a_r9_busy: assert property (@(posedge clk) disable iff (!rstN)
    (!nandWeN || !nandReN) |-> memBusy);

  // R10: two-flop synchronizer
  a_r10_sync: assert property (@(posedge clk) disable iff (!rstN)
    (upCyc == 2'd3) |-> readyStat == $past(nandRb, 2));

  // R2: a low chip enable needs both of its bits
  for (genvar b = 0; b < NB; b++) begin : g_ce
    a_r2_ce_bits: assert property (@(posedge clk) disable iff (!rstN)
      !nandCeN[b] |-> ctrlRdata[2*b] && ctrlRdata[2*b+1]);
  end
endmodule

bind nand_bank_strobe nbs_checker #(.NB(NB), .WE_PULSE(WE_PULSE)) u_chk (
  .clk(clk), .rstN(rstN), .ctrlRdata(ctrlRdata), .memBusy(memBusy),
  .memErr(memErr), .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
  .nandWeN(nandWeN), .nandReN(nandReN), .nandRb(nandRb),
  .readyStat(readyStat)
);

// File: tb/nand_bank_strobe_tb.sv
module nand_bank_strobe_tb;
  localparam int NB = 4;
  localparam int WE_PULSE = 2;

  typedef struct packed {
    logic [31:0] addr;
    logic [7:0]  data;
    logic        eCle;
    logic        eAle;
    logic        eErr;
    logic        eHit;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{32'h1800_0000, 8'hA5, 1'b0, 1'b0, 1'b0, 1'b1},  // data, bank0
    '{32'h1800_8000, 8'h70, 1'b1, 1'b0, 1'b0, 1'b1},  // command
    '{32'h1801_0000, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1},  // address
    '{32'h1401_0004, 8'h12, 1'b0, 1'b1, 1'b0, 1'b1},  // address, low bits set
    '{32'h0C00_0123, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b1},  // data, bank2
    '{32'h0800_8FFF, 8'h90, 1'b1, 1'b0, 1'b0, 1'b1},  // command, bank3
    '{32'h0801_8000, 8'h55, 1'b0, 1'b0, 1'b1, 1'b1},  // both bits: reject
    '{32'h2000_0000, 8'h66, 1'b0, 1'b0, 1'b0, 1'b0}   // outside windows
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWe = 1'b0;
  logic [2*NB-1:0] ctrlWdata = '0;
  logic [2*NB-1:0] ctrlRdata;
  logic memReq = 1'b0, memWe = 1'b0;
  logic [31:0] memAddr = '0;
  logic [7:0] memWdata = '0;
  logic memBusy, memErr, rdValid;
  logic [7:0] rdData;
  logic [NB-1:0] nandCeN;
  logic nandCle, nandAle, nandWeN, nandReN, nandDoe;
  logic [7:0] nandDout;
  logic [7:0] nandDin = '0;
  logic nandRb = 1'b0;
  logic readyStat;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nand_bank_strobe #(.NB(NB), .WE_PULSE(WE_PULSE)) u_dut (
    .clk(clk), .rstN(rstN), .ctrlWe(ctrlWe), .ctrlWdata(ctrlWdata),
    .ctrlRdata(ctrlRdata), .memReq(memReq), .memWe(memWe),
    .memAddr(memAddr), .memWdata(memWdata), .memBusy(memBusy),
    .memErr(memErr), .rdData(rdData), .rdValid(rdValid),
    .nandCeN(nandCeN), .nandCle(nandCle), .nandAle(nandAle),
    .nandWeN(nandWeN), .nandReN(nandReN), .nandDout(nandDout),
    .nandDoe(nandDoe), .nandDin(nandDin), .nandRb(nandRb),
    .readyStat(readyStat)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wrCtrl(input logic [2*NB-1:0] v);
    @(negedge clk);
    ctrlWe = 1'b1;
    ctrlWdata = v;
    @(negedge clk);
    ctrlWe = 1'b0;
  endtask

  function automatic logic [NB-1:0] expCe(input logic [2*NB-1:0] v);
    logic [NB-1:0] r;
    for (int b = 0; b < NB; b++) r[b] = !(v[2*b] && v[2*b+1]);
    return r;
  endfunction

  task automatic runVec(input vec_t v);
    @(negedge clk);
    memReq = 1'b1; memWe = 1'b1; memAddr = v.addr; memWdata = v.data;
    @(negedge clk);
    memReq = 1'b0;
    if (!v.eHit) begin
      chk(!memBusy && !memErr && nandWeN, "R6 miss cycle1",
          {memBusy, memErr, nandWeN}, 3'b001);
      @(negedge clk);
      chk(!memBusy && !memErr && nandWeN, "R6 miss cycle2",
          {memBusy, memErr, nandWeN}, 3'b001);
    end else if (v.eErr) begin
      chk(memErr && !memBusy && nandWeN && !nandCle && !nandAle, "R5 reject",
          {memErr, memBusy, nandWeN, nandCle, nandAle}, 5'b10100);
      @(negedge clk);
      chk(!memErr && nandWeN, "R5 err one cycle", {memErr, nandWeN}, 2'b01);
    end else begin
      chk(nandCle == v.eCle && nandAle == v.eAle, "R4 lines in setup",
          {nandCle, nandAle}, {v.eCle, v.eAle});
      chk(nandWeN && memBusy && nandDoe && nandDout == v.data, "R7 setup",
          {nandWeN, memBusy, nandDoe, nandDout}, {3'b111, v.data});
      for (int k = 0; k < WE_PULSE; k++) begin
        @(negedge clk);
        chk(!nandWeN && nandReN, "R7 strobe low", {nandWeN, nandReN}, 2'b01);
        chk(nandCle == v.eCle && nandAle == v.eAle, "R4 lines in strobe",
            {nandCle, nandAle}, {v.eCle, v.eAle});
      end
      @(negedge clk);
      chk(nandWeN && memBusy && nandCle == v.eCle && nandAle == v.eAle &&
          nandDout == v.data, "R7 hold",
          {nandWeN, memBusy, nandCle, nandAle}, {2'b11, v.eCle, v.eAle});
      @(negedge clk);
      chk(!memBusy && !nandCle && !nandAle && !nandDoe, "R9 end of cycle",
          {memBusy, nandCle, nandAle, nandDoe}, 4'b0000);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(ctrlRdata == '0 && nandCeN == '1, "R1 reset reg/ce",
        {ctrlRdata, nandCeN}, {8'h00, 4'hF});
    chk(!nandCle && !nandAle && nandWeN && nandReN && !nandDoe &&
        !memBusy && !memErr, "R1 reset bus",
        {nandCle, nandAle, nandWeN, nandReN, nandDoe, memBusy, memErr},
        7'b0011000);
    rstN = 1'b1;
    @(negedge clk);

    // stimulus table
    for (int i = 0; i < NV; i++) runVec(VEC[i]);

    // R2: bit mapping of the control register
    wrCtrl(8'h55);
    chk(nandCeN == 4'hF, "R2 enables only", nandCeN, 4'hF);
    wrCtrl(8'h02);
    chk(nandCeN == 4'hF, "R2 assert only", nandCeN, 4'hF);
    wrCtrl(8'h03);
    chk(nandCeN == expCe(8'h03) && nandCeN == 4'hE, "R2 bank0", nandCeN, 4'hE);
    wrCtrl(8'h30);
    chk(nandCeN == 4'hB, "R2 bank2", nandCeN, 4'hB);
    wrCtrl(8'hFF);
    chk(nandCeN == 4'h0, "R2 all banks", nandCeN, 4'h0);

    // R3: clear assert mask, then all zero
    wrCtrl(ctrlRdata & ~8'hAA);
    chk(nandCeN == 4'hF && ctrlRdata == 8'h55, "R3 mask clear",
        {ctrlRdata, nandCeN}, {8'h55, 4'hF});
    wrCtrl(8'h0F);
    chk(nandCeN == 4'hC, "R2 bank0+1", nandCeN, 4'hC);
    wrCtrl(8'h00);
    chk(nandCeN == 4'hF && ctrlRdata == 8'h00, "R3 write zero",
        {ctrlRdata, nandCeN}, {8'h00, 4'hF});

    // R8: read cycle at a command offset stays a data read
    @(negedge clk);
    nandDin = 8'h9E;
    memReq = 1'b1; memWe = 1'b0; memAddr = 32'h1800_8000;
    @(negedge clk);
    memReq = 1'b0;
    chk(memBusy && nandReN && !nandDoe && !nandCle && !nandAle, "R8 read setup",
        {memBusy, nandReN, nandDoe, nandCle, nandAle}, 5'b11000);
    for (int k = 0; k < WE_PULSE; k++) begin
      @(negedge clk);
      chk(!nandReN && nandWeN && !rdValid, "R8 read strobe",
          {nandReN, nandWeN, rdValid}, 3'b010);
    end
    @(negedge clk);
    chk(rdValid && rdData == 8'h9E && nandReN, "R8 read data",
        {rdValid, rdData}, {1'b1, 8'h9E});
    @(negedge clk);
    chk(!rdValid && !memBusy, "R8 valid one cycle", {rdValid, memBusy}, 2'b00);

    // R10: two-flop ready sync
    nandRb = 1'b1;
    @(negedge clk);
    chk(!readyStat, "R10 not after one edge", readyStat, 1'b0);
    @(negedge clk);
    chk(readyStat, "R10 after two edges", readyStat, 1'b1);
    nandRb = 1'b0;
    @(negedge clk);
    chk(readyStat, "R10 fall one edge", readyStat, 1'b1);
    @(negedge clk);
    chk(!readyStat, "R10 fall two edges", readyStat, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule